// File: doc/BRIEF.md
# Voltage and Frequency Operating-Point Sequencer

This controller moves a supply-voltage code and a clock-frequency code from the present operating point to a requested one. It never lets the frequency code run ahead of what the present voltage code supports. A request names only a target frequency code. The voltage that frequency needs comes from a ceiling formula, so every completed move leaves the pair on a known curve.

When the frequency rises, the voltage climbs first, one code per step. Each step waits for the regulator's settled indication. The frequency then changes in a single jump. When the frequency falls, the jump comes first and the voltage then steps down. The core runs during voltage steps and is stalled only while the PLL relocks after a jump.

A request that arrives during a move is held, and the newest one wins. It starts once the current move is over. A missing settled or lock indication ends the move after a fixed number of cycles. The move then stops at a legal point and an error flag is raised.

Top module: `vf_sequencer`

## Requirements
- R1: After reset, vcode and fcode are 0 and core_stall, busy and timeout_err are low.
- R2: The required voltage code for frequency code f is vmin(f) = ceil(f*(2^VW-1)/(2^FW-1)). A move that completes without timeout ends with fcode equal to the target. On a decrease it ends with vcode = vmin(target). On an increase it ends with vcode = max(vmin(target), previous vcode).
- R3: At every cycle, vcode >= vmin(fcode).
- R4: Each voltage change is exactly +1 or -1 code, and each move changes fcode at most once. On an increase, every voltage step comes before the frequency jump.
- R5: On a decrease, the frequency jump comes before any voltage step.
- R6: After a voltage step, vcode holds until volt_settled is sampled high. The next step follows one cycle later, so steps are settle-latency + 1 cycles apart.
- R7: core_stall rises in the cycle fcode changes and falls on the edge that samples pll_locked high. It is never high while vcode changes.
- R8: busy is high from the edge that samples req_valid until the move ends. A request equal to the current fcode changes neither code.
- R9: A request taken while busy is held, and a later one replaces it. It is applied after the move in progress completes.
- R10: If the awaited indication is missing for TMO_CYC cycles in a wait, timeout_err rises exactly TMO_CYC cycles after the code change. The move then ends with stall released and both codes left where they are. timeout_err clears when the next move starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Target request strobe |
| req_fcode | input | FW | Target frequency code |
| volt_settled | input | 1 | Regulator reports the last voltage step settled |
| pll_locked | input | 1 | PLL reports lock on the new frequency |
| vcode | output | VW | Supply voltage code |
| fcode | output | FW | Clock frequency code |
| core_stall | output | 1 | Core held while the PLL relocks |
| busy | output | 1 | Request pending or move in progress |
| timeout_err | output | 1 | Last wait ended without its indication |

## Verification
- busy is due one cycle after the strobe edge.
- A voltage step lands one cycle after its settled pulse is sampled, so steps sit settle-latency + 1 cycles apart.
- The stall spans exactly the lock latency, and a timeout lands exactly TMO_CYC cycles after the code change that opened the wait.

A bench-side regulator and PLL model answers each change after a latency that varies per move. Every check samples on the falling edge and measures intervals between observed changes. All 256 ordered pairs of frequency codes are swept.

// File: rtl/vf_sequencer.sv
module vf_sequencer #(
  parameter int VW      = 5,
  parameter int FW      = 4,
  parameter int TMO_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [FW-1:0] req_fcode,
  input  logic          volt_settled,
  input  logic          pll_locked,
  output logic [VW-1:0] vcode,
  output logic [FW-1:0] fcode,
  output logic          core_stall,
  output logic          busy,
  output logic          timeout_err
);
  localparam int NV = 1 << VW;
  localparam int NF = 1 << FW;
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_VSTEP, S_VWAIT, S_FJUMP, S_LOCK} st_t;

  function automatic logic [VW-1:0] vfloor(input logic [FW-1:0] f);
    int t;
    t = (int'(f) * (NV - 1) + NF - 2) / (NF - 1);
    return t[VW-1:0];
  endfunction

  st_t           st;
  logic          pend, lowering;
  logic [FW-1:0] pend_f, goal_f;
  logic [VW-1:0] goal_v;
  logic [TW-1:0] tcnt;

  wire tmo_hit = (tcnt == TW'(TMO_CYC - 1));

  assign core_stall = (st == S_LOCK);
  assign busy       = (st != S_IDLE) || pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pend        <= 1'b0;
      pend_f      <= '0;
      goal_f      <= '0;
      goal_v      <= '0;
      lowering    <= 1'b0;
      tcnt        <= '0;
      vcode       <= '0;
      fcode       <= '0;
      timeout_err <= 1'b0;
    end else begin
      if (req_valid) begin
        pend   <= 1'b1;
        pend_f <= req_fcode;
      end
      case (st)
        S_IDLE: if (pend) begin
          if (!req_valid) pend <= 1'b0;
          goal_f <= pend_f;
          goal_v <= vfloor(pend_f);
          if (pend_f != fcode) begin
            timeout_err <= 1'b0;
            if (pend_f > fcode) begin
              lowering <= 1'b0;
              st       <= (vfloor(pend_f) > vcode) ? S_VSTEP : S_FJUMP;
            end else begin
              lowering <= 1'b1;
              st       <= S_FJUMP;
            end
          end
        end
        S_VSTEP: begin
          vcode <= (vcode < goal_v) ? vcode + 1'b1 : vcode - 1'b1;
          tcnt  <= '0;
          st    <= S_VWAIT;
        end
        S_VWAIT: begin
          if (volt_settled) begin
            if (vcode != goal_v) st <= S_VSTEP;
            else                 st <= lowering ? S_IDLE : S_FJUMP;
          end else if (tmo_hit) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_FJUMP: begin
          fcode <= goal_f;
          tcnt  <= '0;
          st    <= S_LOCK;
        end
        S_LOCK: begin
          if (pll_locked) begin
            st <= (lowering && vcode > goal_v) ? S_VSTEP : S_IDLE;
          end else if (tmo_hit) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module vf_sequencer_chk #(
  parameter int VW = 5,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pll_locked,
  input logic [VW-1:0] vcode,
  input logic [FW-1:0] fcode,
  input logic          core_stall,
  input logic          busy,
  input logic          timeout_err
);
  function automatic int need_v(input logic [FW-1:0] f);
    return (int'(f) * ((1 << VW) - 1) + (1 << FW) - 2) / ((1 << FW) - 1);
  endfunction

  AST_SAFE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vcode) >= need_v(fcode)); // R3
  AST_UNIT_VSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcode) |-> (vcode == $past(vcode) + 1'b1 || vcode + 1'b1 == $past(vcode))); // R4
  AST_STALL_ON_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fcode) |-> core_stall); // R7
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stall) |-> !$stable(fcode)); // R7
  AST_NO_VSTEP_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> $stable(vcode)); // R7
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall && pll_locked |=> !core_stall); // R7
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> busy); // R8
  AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !core_stall); // R10
endmodule

bind vf_sequencer vf_sequencer_chk #(.VW(VW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .vcode(vcode),
  .fcode(fcode), .core_stall(core_stall), .busy(busy), .timeout_err(timeout_err)
);

// File: tb/test_vf_sequencer.sv
`timescale 1ns/1ps
module test_vf_sequencer;
  localparam int VW = 5, FW = 4, TMO = 40;
  logic clk = 0, rst_n = 0, req_valid = 0, volt_settled = 0, pll_locked = 0;
  logic [FW-1:0] req_fcode = '0;
  logic [VW-1:0] vcode;
  logic [FW-1:0] fcode;
  logic core_stall, busy, timeout_err;

  vf_sequencer #(.VW(VW), .FW(FW), .TMO_CYC(TMO)) i_vf_sequencer (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int dv = 1, dl = 1;
  bit resp_v = 1, resp_f = 1, done = 0;
  int nv, nf, vbef, vaft, stall_n, unsafe, gapbad, last_vc, seen15;
  int vchg_cyc, ferr_cyc;

  function automatic int vmin(int f);
    return (f * 31 + 14) / 15;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // regulator and PLL model
  initial begin
    int vc = 0, fc = 0;
    logic [VW-1:0] lv = '0;
    logic [FW-1:0] lf = '0;
    forever begin
      @(negedge clk);
      if (vcode != lv) begin lv = vcode; vc = dv; end else if (vc > 0) vc--;
      if (fcode != lf) begin lf = fcode; fc = dl; end else if (fc > 0) fc--;
      volt_settled = resp_v && (vc == 1);
      pll_locked   = resp_f && (fc == 1);
    end
  end

  // observer
  initial begin
    logic [VW-1:0] pv = '0;
    logic [FW-1:0] pf = '0;
    logic perr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (int'(vcode) < vmin(int'(fcode))) unsafe++;
        if (core_stall) stall_n++;
        if (fcode == 15) seen15 = 1;
        if (fcode != pf) begin nf++; last_vc = -1; end
        if (vcode != pv) begin
          nv++;
          if (nf > 0) vaft++; else vbef++;
          if (last_vc >= 0 && cyc - last_vc != dv + 1) gapbad++;
          last_vc = cyc;
          vchg_cyc = cyc;
        end
        if (timeout_err && !perr) ferr_cyc = cyc;
      end
      pv = vcode; pf = fcode; perr = timeout_err;
    end
  end

  initial begin
    #(190000 * 10);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  task automatic clear_stats();
    nv = 0; nf = 0; vbef = 0; vaft = 0; stall_n = 0; unsafe = 0;
    gapbad = 0; last_vc = -1; seen15 = 0;
  endtask

  task automatic request(int tf);
    @(negedge clk);
    req_valid = 1; req_fcode = FW'(tf);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R8 busy after request", busy, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic move(int tf);
    int f0, v0, ev;
    f0 = int'(fcode); v0 = int'(vcode);
    clear_stats();
    request(tf);
    wait_idle();
    ev = (tf < f0) ? vmin(tf) : (tf == f0 ? v0 : (vmin(tf) > v0 ? vmin(tf) : v0));
    chk(int'(fcode) == tf, "R2 final fcode", int'(fcode), tf);
    chk(int'(vcode) == ev, "R2 final vcode", int'(vcode), ev);
    chk(unsafe == 0, "R3 voltage below need", unsafe, 0);
    chk(nv == (ev > v0 ? ev - v0 : v0 - ev), "R4 voltage step count", nv, (ev > v0 ? ev - v0 : v0 - ev));
    chk(nf == (tf != f0), "R4 single frequency jump", nf, int'(tf != f0));
    if (tf > f0) chk(vaft == 0, "R4 voltage after jump on raise", vaft, 0);
    if (tf < f0) chk(vbef == 0, "R5 voltage before jump on lower", vbef, 0);
    chk(gapbad == 0, "R6 step spacing", gapbad, 0);
    chk(stall_n == (tf != f0 ? dl : 0), "R7 stall length", stall_n, (tf != f0 ? dl : 0));
    chk(timeout_err == 0 && core_stall == 0, "R10 no error on clean move", timeout_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vcode == 0 && fcode == 0, "R1 reset codes", int'(vcode) * 100 + int'(fcode), 0);
    chk(!core_stall && !busy && !timeout_err, "R1 reset flags", int'({core_stall, busy, timeout_err}), 0);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        dv = 1 + (a + b) % 4;
        dl = 1 + (a * 3 + b) % 5;
        move(a);
        move(b);
      end

    // R9: queued requests, newest wins
    dv = 2; dl = 2;
    move(0);
    clear_stats();
    request(15);
    repeat (3) @(negedge clk);
    req_valid = 1; req_fcode = 4'd5;
    @(negedge clk);
    req_fcode = 4'd9;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    chk(seen15 == 1, "R9 first move completed", seen15, 1);
    chk(fcode == 9, "R9 latest request applied", int'(fcode), 9);
    chk(int'(vcode) == vmin(9), "R9 voltage after queued lower", int'(vcode), vmin(9));

    // R10: settle timeout on a raise
    move(3);
    resp_v = 0;
    clear_stats();
    request(12);
    wait_idle();
    chk(ferr_cyc - vchg_cyc == TMO, "R10 settle timeout latency", ferr_cyc - vchg_cyc, TMO);
    chk(timeout_err == 1, "R10 error raised", timeout_err, 1);
    chk(fcode == 3, "R10 frequency kept on abort", int'(fcode), 3);
    chk(int'(vcode) == vmin(3) + 1, "R10 voltage left at step", int'(vcode), vmin(3) + 1);
    resp_v = 1;
    move(6);

    // R10: lock timeout
    resp_f = 0;
    clear_stats();
    request(7);
    wait_idle();
    chk(stall_n == TMO, "R10 lock timeout stall length", stall_n, TMO);
    chk(timeout_err == 1 && !core_stall, "R10 lock error releases stall", timeout_err, 1);
    chk(fcode == 7 && int'(vcode) == vmin(7), "R10 codes after lock abort", int'(vcode), vmin(7));
    resp_f = 1;
    move(2);

    finish_run();
  end
endmodule